// File: doc/BRIEF.md
# Bank-Aware Low-Power Memory Self-Test Controller

This block runs a March C- self-test on a bit-oriented SRAM whose cell array is cut into groups of consecutive rows (row banks), each with its own precharge control. After a start pulse it walks a fixed sequence of write and read accesses over every cell, compares each read against the value the algorithm expects, and reports the result on a sticky fail flag and a done flag.

Because the test address sequence is fully predictable, the controller knows which row bank each access will hit before the access happens. It derives one precharge enable per bank from the address it is about to present. In low-power mode only the enable of the bank that holds the accessed row is raised. In normal mode every bank is precharged. Each access takes two cycles: a setup cycle where address, data and precharge enables settle with the strobe low, then the strobe cycle. The SRAM returns read data on the cycle after a read strobe.

The array, the precharge circuits and the wordline drivers are outside the block. The row count, column count, bank count and data width are parameters. Rows, columns and banks must be powers of two, there must be at least two banks, and the row count must divide evenly by the bank count.

Top module: `lp_mbist_ctrl`

## Requirements
- R1: While reset is held and after its release with no start, mem_en_o, mem_we_o, done_o, fail_o and every bit of pchg_en_o are 0.
- R2: A start pulse in idle or done state runs six march elements in this order: ascending write 0; ascending read 0 then write 1; ascending read 1 then write 0; descending read 0 then write 1; descending read 1 then write 0; ascending read 0. That is 10 accesses per cell. A write drives every bit of mem_wdata_o to the element's value.
- R3: The linear address is row*COLS+col, with the column in the low bits. Ascending elements visit 0 up to ROWS*COLS-1 and descending elements visit the reverse. Every operation of an element is applied to one address before the address moves.
- R4: Every access has a setup cycle with mem_en_o low, followed by a strobe cycle with mem_en_o high. Address, write data and pchg_en_o are identical in both cycles, and mem_en_o is never high on two consecutive cycles.
- R5: In low-power mode, during both cycles of an access, exactly one bit of pchg_en_o is high. That bit is number addr/(ROWS*COLS/BANKS), which equals the top log2(BANKS) address bits.
- R6: In normal mode all BANKS bits of pchg_en_o are high throughout the run.
- R7: While idle or done, pchg_en_o is all zero and mem_en_o is low.
- R8: lowpwr_i is sampled only on the accepted start. Changing it during a run has no effect on pchg_en_o.
- R9: Any read whose data differs from the expected value sets fail_o. fail_o stays set until the next accepted start, which clears it. fail_o is final when done_o rises.
- R10: done_o rises after the last read of the final element has been compared. It stays high until the next start. A start during a run is ignored.
- R11: A start while done restarts the full sequence from the first element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| lowpwr_i | input | 1 | 1 selects low-power (single-bank) precharge |
| mem_addr_o | output | log2(ROWS*COLS) | Linear cell address |
| mem_wdata_o | output | DW | Write data |
| mem_en_o | output | 1 | Access strobe |
| mem_we_o | output | 1 | Write select, valid with mem_en_o |
| mem_rdata_i | input | DW | Read data, one cycle after a read strobe |
| pchg_en_o | output | BANKS | Per-row-bank precharge enables |
| done_o | output | 1 | Test complete |
| fail_o | output | 1 | Sticky miscompare flag |

## Verification
On every cycle the assertions check the precharge encoding: one-hot in low-power runs, all-ones in normal runs and zero when idle. They also check that address and enables hold steady across each strobe, that strobes never occur back to back, that address steps are single, that the fail flag is sticky and that done holds. Only the bench scenarios can show the exact order of all accesses, because they are compared against an independently built list. The same applies to the bank chosen for each address, to the mode being ignored mid-run, to a stuck cell being caught, and to the fail flag clearing on restart.

// File: rtl/lp_mbist_pkg.sv
package lp_mbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } run_state_e;

  typedef struct packed {
    logic up;       // address direction
    logic two_ops;  // element has a second operation
    logic op0_rd;   // first op is a read
    logic op0_val;  // first op data / expectation
    logic op1_rd;
    logic op1_val;
  } march_elem_t;

  localparam logic [2:0] LAST_ELEM = 3'd5;

  function automatic march_elem_t elem_info(input logic [2:0] idx);
    march_elem_t e;
    case (idx)
      3'd0:    e = '{up: 1'b1, two_ops: 1'b0, op0_rd: 1'b0, op0_val: 1'b0, op1_rd: 1'b0, op1_val: 1'b0};
      3'd1:    e = '{up: 1'b1, two_ops: 1'b1, op0_rd: 1'b1, op0_val: 1'b0, op1_rd: 1'b0, op1_val: 1'b1};
      3'd2:    e = '{up: 1'b1, two_ops: 1'b1, op0_rd: 1'b1, op0_val: 1'b1, op1_rd: 1'b0, op1_val: 1'b0};
      3'd3:    e = '{up: 1'b0, two_ops: 1'b1, op0_rd: 1'b1, op0_val: 1'b0, op1_rd: 1'b0, op1_val: 1'b1};
      3'd4:    e = '{up: 1'b0, two_ops: 1'b1, op0_rd: 1'b1, op0_val: 1'b1, op1_rd: 1'b0, op1_val: 1'b0};
      default: e = '{up: 1'b1, two_ops: 1'b0, op0_rd: 1'b1, op0_val: 1'b0, op1_rd: 1'b0, op1_val: 1'b0};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_up,
  input  logic          step,
  input  logic          dir_up,
  output logic [AW-1:0] addr,
  output logic          at_end
);

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_d  = addr_q;
    addr_en = load | step;
    if (load) begin
      addr_d = load_up ? '0 : '1;
    end else if (step) begin
      addr_d = dir_up ? (addr_q + AW'(1)) : (addr_q - AW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr   = addr_q;
  assign at_end = dir_up ? (&addr_q) : (addr_q == '0);

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && dir_up) |=> (addr_q == $past(addr_q) + AW'(1)));

  // R3
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !dir_up) |=> (addr_q == $past(addr_q) - AW'(1)));

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import lp_mbist_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode,
  input  logic addr_last,
  output logic load,
  output logic load_up,
  output logic step,
  output logic dir_up,
  output logic run,
  output logic lp,
  output logic acc,
  output logic wr,
  output logic rd,
  output logic val,
  output logic clr,
  output logic done
);

  run_state_e  state_q, state_d;
  logic [2:0]  elem_q, elem_d;
  logic        op_q, op_d;
  logic        acc_q, acc_d;
  logic        lp_q, lp_d;
  march_elem_t info, info_nxt;
  logic        cur_rd, cur_val;

  always_comb begin
    info     = elem_info(elem_q);
    info_nxt = elem_info(3'(elem_q + 3'd1));
    cur_rd   = op_q ? info.op1_rd  : info.op0_rd;
    cur_val  = op_q ? info.op1_val : info.op0_val;
  end

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    op_d    = op_q;
    acc_d   = acc_q;
    lp_d    = lp_q;
    load    = 1'b0;
    load_up = 1'b1;
    step    = 1'b0;
    clr     = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_RUN;
          elem_d  = 3'd0;
          op_d    = 1'b0;
          acc_d   = 1'b0;
          lp_d    = mode;
          load    = 1'b1;
          clr     = 1'b1;
        end
      end
      ST_RUN: begin
        if (!acc_q) begin
          acc_d = 1'b1;
        end else begin
          acc_d = 1'b0;
          if (info.two_ops && !op_q) begin
            op_d = 1'b1;
          end else begin
            op_d = 1'b0;
            if (!addr_last) begin
              step = 1'b1;
            end else if (elem_q != LAST_ELEM) begin
              elem_d  = 3'(elem_q + 3'd1);
              load    = 1'b1;
              load_up = info_nxt.up;
            end else begin
              state_d = ST_DRAIN;
            end
          end
        end
      end
      default: state_d = ST_DONE;  // drain: last compare in flight
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= 3'd0;
      op_q    <= 1'b0;
      acc_q   <= 1'b0;
      lp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      elem_q  <= elem_d;
      op_q    <= op_d;
      acc_q   <= acc_d;
      lp_q    <= lp_d;
    end
  end

  assign dir_up = info.up;
  assign run    = (state_q == ST_RUN);
  assign lp     = lp_q;
  assign acc    = run & acc_q;
  assign wr     = acc & ~cur_rd;
  assign rd     = acc & cur_rd;
  assign val    = cur_val;
  assign done   = (state_q == ST_DONE);

  // R4
  acc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !acc);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_DONE) |-> !acc);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(lp_q));

endmodule

// File: rtl/mbist_pchg_dec.sv
module mbist_pchg_dec #(
  parameter int unsigned BANKS = 8,
  parameter int unsigned BW    = $clog2(BANKS)
) (
  input  logic [BW-1:0]    bank,
  input  logic             run,
  input  logic             lp,
  output logic [BANKS-1:0] pchg
);

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign pchg[g] = run & (~lp | (bank == BW'(g)));
  end

  // R5
  always_comb lp_onehot_chk: assert (!(run && lp) || $countones(pchg) == 1);
  // R6
  always_comb full_chk: assert (!(run && !lp) || (&pchg));
  // R7
  always_comb off_chk: assert (run || pchg == '0);

endmodule

// File: rtl/mbist_resp_cmp.sv
module mbist_resp_cmp #(
  parameter int unsigned DW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          chk,
  input  logic          exp_val,
  input  logic [DW-1:0] rdata,
  output logic          fail
);

  logic chk_q, exp_q, fail_q, fail_d, miss;

  always_comb begin
    miss   = chk_q && (rdata != {DW{exp_q}});
    fail_d = clr ? 1'b0 : (fail_q | miss);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q  <= 1'b0;
      exp_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      chk_q  <= chk;
      exp_q  <= exp_val;
      fail_q <= fail_d;
    end
  end

  assign fail = fail_q;

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr) |=> fail_q);

  // R9
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(chk_q));

endmodule

// File: rtl/lp_mbist_ctrl.sv
module lp_mbist_ctrl #(
  parameter int unsigned ROWS  = 256,
  parameter int unsigned COLS  = 256,
  parameter int unsigned BANKS = 8,
  parameter int unsigned DW    = 1,
  localparam int unsigned AW   = $clog2(ROWS) + $clog2(COLS),
  localparam int unsigned BW   = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             lowpwr_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             mem_en_o,
  output logic             mem_we_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [BANKS-1:0] pchg_en_o,
  output logic             done_o,
  output logic             fail_o
);

  logic          load, load_up, step, dir_up, addr_last;
  logic          run, lp, acc, wr, rd, val, clr, done;
  logic [AW-1:0] addr;
  logic [BW-1:0] bank;

  mbist_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .mode      (lowpwr_i),
    .addr_last (addr_last),
    .load      (load),
    .load_up   (load_up),
    .step      (step),
    .dir_up    (dir_up),
    .run       (run),
    .lp        (lp),
    .acc       (acc),
    .wr        (wr),
    .rd        (rd),
    .val       (val),
    .clr       (clr),
    .done      (done)
  );

  mbist_addr_gen #(.AW(AW)) i_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_up (load_up),
    .step    (step),
    .dir_up  (dir_up),
    .addr    (addr),
    .at_end  (addr_last)
  );

  assign bank = addr[AW-1 -: BW];

  mbist_pchg_dec #(.BANKS(BANKS), .BW(BW)) i_pchg (
    .bank (bank),
    .run  (run),
    .lp   (lp),
    .pchg (pchg_en_o)
  );

  mbist_resp_cmp #(.DW(DW)) i_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .chk     (rd),
    .exp_val (val),
    .rdata   (mem_rdata_i),
    .fail    (fail_o)
  );

  assign mem_addr_o  = addr;
  assign mem_wdata_o = {DW{val}};
  assign mem_en_o    = acc;
  assign mem_we_o    = wr;
  assign done_o      = done;

  // R4
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_o |-> ($stable(mem_addr_o) && $stable(pchg_en_o) && $stable(mem_wdata_o)));

  // R5
  bank_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && lp) |-> pchg_en_o[mem_addr_o[AW-1 -: BW]]);

endmodule

// File: tb/test_lp_mbist_ctrl.sv
module test_lp_mbist_ctrl;

  localparam int unsigned ROWS  = 16;
  localparam int unsigned COLS  = 8;
  localparam int unsigned BANKS = 4;
  localparam int unsigned DW    = 1;
  localparam int unsigned AW    = $clog2(ROWS) + $clog2(COLS);
  localparam int unsigned N     = ROWS * COLS;
  localparam int unsigned PER_B = N / BANKS;

  typedef struct packed {
    logic             we;
    logic             val;
    logic [AW-1:0]    addr;
    logic [BANKS-1:0] pchg;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             lowpwr = 1'b0;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_wdata;
  logic             mem_en, mem_we;
  logic [DW-1:0]    mem_rdata = '0;
  logic [BANKS-1:0] pchg;
  logic             done, fail;

  int checks = 0;
  int errs   = 0;
  bit finished = 0;
  bit fault_on = 0;
  int unsigned fault_addr = 37;

  exp_t exp_q[$];
  logic [DW-1:0] mem [N];
  logic             prev_en;
  logic [AW-1:0]    prev_addr;
  logic [BANKS-1:0] prev_pchg;

  always #10 clk = ~clk;  // 50 MHz

  lp_mbist_ctrl #(.ROWS(ROWS), .COLS(COLS), .BANKS(BANKS), .DW(DW)) i_lp_mbist_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .lowpwr_i    (lowpwr),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_en_o    (mem_en),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .pchg_en_o   (pchg),
    .done_o      (done),
    .fail_o      (fail)
  );

  // behavioural SRAM with optional stuck-at-1 cell
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= (fault_on && mem_addr == AW'(fault_addr)) ? '1 : mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // driver side: push the expected access stream
  task automatic build_exp(input bit lp_mode);
    exp_q.delete();
    for (int e = 0; e < 6; e++) begin
      bit up  = !(e == 3 || e == 4);
      int nop = (e == 0 || e == 5) ? 1 : 2;
      for (int i = 0; i < N; i++) begin
        int unsigned a = up ? i : N - 1 - i;
        for (int o = 0; o < nop; o++) begin
          exp_t x;
          x.addr = AW'(a);
          x.pchg = lp_mode ? BANKS'(1 << (a / PER_B)) : '1;
          if (e == 0)      begin x.we = 1'b1; x.val = 1'b0; end
          else if (o == 1) begin x.we = 1'b1; x.val = (e == 1 || e == 3); end
          else             begin x.we = 1'b0; x.val = (e == 2 || e == 4); end
          exp_q.push_back(x);
        end
      end
    end
  endtask

  // monitor: pop and compare each strobe, check setup cycle and idle quiet
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en) begin
        exp_t x;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected extra access", 64'(mem_addr), 64'hffff);
        end else begin
          x = exp_q.pop_front();
          chk(mem_addr == x.addr, "R2/R3 address", 64'(mem_addr), 64'(x.addr));
          chk(mem_we == x.we, "R2 operation kind", 64'(mem_we), 64'(x.we));
          if (x.we) chk(mem_wdata == {DW{x.val}}, "R2 write data", 64'(mem_wdata), 64'(x.val));
          chk(pchg == x.pchg, "R5/R6 precharge enables", 64'(pchg), 64'(x.pchg));
        end
        chk(!prev_en && prev_addr == mem_addr && prev_pchg == pchg,
            "R4 setup cycle before strobe", {prev_en, 31'd0, 32'(prev_pchg)}, {32'd0, 32'(pchg)});
      end
      if (done) chk(pchg == '0 && !mem_en, "R7 quiet while done", 64'(pchg), 64'd0);
    end
    prev_en   = mem_en;
    prev_addr = mem_addr;
    prev_pchg = pchg;
  end

  task automatic run_test(input bit lp_mode, input bit flip_mode, input bit poke_start, input string tag);
    int cyc;
    build_exp(lp_mode);
    @(negedge clk);
    lowpwr = lp_mode;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (flip_mode) lowpwr = !lp_mode;  // R8: must be ignored
    chk(!done && !fail, {tag, " R9/R11 flags cleared after start"}, {63'd0, done | fail}, 64'd0);
    if (poke_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;               // R10: ignored while running
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20 * N + 20) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, {tag, " R10 done raised"}, 64'(done), 64'd1);
    chk(exp_q.size() == 0, {tag, " R2 all accesses seen"}, 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_en && !mem_we && !done && !fail && pchg == '0, "R1 outputs in reset",
        {59'd0, mem_en, mem_we, done, fail, 1'b0}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_en && !done && !fail && pchg == '0, "R1/R7 idle after reset",
        {60'd0, mem_en, done, fail, |pchg}, 64'd0);

    run_test(1'b1, 1'b0, 1'b0, "lp clean");
    chk(!fail, "R9 no fail on clean array", 64'(fail), 64'd0);

    run_test(1'b0, 1'b1, 1'b1, "normal mode-flip");
    chk(!fail, "R9 no fail in normal run", 64'(fail), 64'd0);

    fault_on = 1'b1;
    run_test(1'b1, 1'b1, 1'b0, "lp stuck cell");
    chk(fail, "R9 stuck cell detected", 64'(fail), 64'd1);
    repeat (20) @(negedge clk);
    chk(done && fail, "R10/R9 done and fail held", {62'd0, done, fail}, 64'd3);

    fault_on = 1'b0;
    run_test(1'b1, 1'b0, 1'b0, "lp restart");
    chk(!fail, "R11 restart clean run", 64'(fail), 64'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

endmodule